// File: doc/BRIEF.md
# Table-Driven Datapath Sequencer

This block is a small self-running compute engine. Two operand registers, A and B, feed an eight-function ALU. A control table supplies the controls in every cycle. The table holds one word per state and is read at the address of the present state. Each word gives three things: the ALU function, a load enable for each register, and the state for the next cycle. The ALU result is written back into whichever register is enabled.

After reset the table holds a default program that loops over three steps without end. The first step adds and writes the sum into A. The second subtracts B from A and writes the difference into B. The third ORs the two registers and writes the result into A. When the writable variant is built, a write port can overwrite any table word. The same datapath then runs a different sequence of operations, with no change to the hardware.

Top module: `tds_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes 00, A takes the value `A_INIT` and B takes the value `B_INIT`.
- R2: A word with function code 011 performs addition. The default word for state 00 is next 01, function 011, A load only, so A becomes (A+B) mod 2^DATA_W.
- R3: Function code 010 computes A minus B with a carry-in of 1, which gives the exact difference modulo 2^DATA_W. The default word for state 01 is next 10, function 010, B load only.
- R4: Function code 101 is bitwise OR. The default word for state 10 is next 00, function 101, A load only.
- R5: Under the default table the state visits 00, 01, 10, 00 and repeats this loop indefinitely.
- R6: A register captures the ALU result on a rising edge only when its own load bit in the current word is 1. Otherwise it keeps its value.
- R7: A table word is STATE_W+5 bits wide. The next state sits in the top STATE_W bits, the function in bits [4:2], the A load in bit 1 and the B load in bit 0. When `tbl_we` is high at a rising edge, `tbl_wdata` is stored at `tbl_addr`.
- R8: Writing the word of the current state does not change the step being executed in that cycle. The new word is used from the next visit to that state.
- R9: Each state without a default step (11 for STATE_W=2) has the default word next 00, function 000, no loads. Such a state returns to 00 and leaves A and B unchanged.
- R10: The remaining function codes are: 000 gives all zeros, 001 gives B minus A, 100 gives XOR, 110 gives AND and 111 gives all ones.
- R11: Reset restores the whole default table, and it takes priority over a table write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | STATE_W | Address of the table word to write |
| tbl_wdata | input | STATE_W+5 | Table word to write |
| state | output | STATE_W | Present state |
| fn | output | 3 | ALU function code from the present word |
| load_a | output | 1 | A load bit from the present word |
| load_b | output | 1 | B load bit from the present word |
| a_val | output | DATA_W | Contents of register A |
| b_val | output | DATA_W | Contents of register B |

## Verification
The default program runs for several dozen cycles from operand values chosen so that the sums wrap past 2^DATA_W. This exercises the carry-in of the subtract step, as opposed to a plain inverted operand. Reprogrammed sequences then apply every function code, each with a target register and an operand mix whose result differs between neighbouring codes. They also route the machine through the unused state, which shows whether its default word leaves both registers untouched. Writes are timed to land on the word of the present state, on the word of the next state, and in the same cycle as a reset. These cases separate a write that takes effect at the next visit from one that takes effect at once, and a reset that rebuilds the table from one that does not.

// File: rtl/tds_pkg.sv
package tds_pkg;

   localparam int FN_W = 3;

   typedef enum logic [FN_W-1:0] {
      FN_ZERO  = 3'b000,
      FN_BSUBA = 3'b001,
      FN_ASUBB = 3'b010,
      FN_ADD   = 3'b011,
      FN_XOR   = 3'b100,
      FN_OR    = 3'b101,
      FN_AND   = 3'b110,
      FN_ONES  = 3'b111
   } alu_fn_e;

endpackage

// File: rtl/tds_alu.sv
module tds_alu
   import tds_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y
);

   logic [W-1:0] add_x, add_y, sum;
   logic         cin;

   // One shared adder serves add and both subtract directions
   always_comb begin
      add_x = a;
      add_y = b;
      cin   = 1'b0;
      case (fn)
         FN_ASUBB: begin add_y = ~b; cin = 1'b1; end
         FN_BSUBA: begin add_x = b; add_y = ~a; cin = 1'b1; end
         default: ;
      endcase
      sum = add_x + add_y + W'(cin);
   end

   always_comb begin
      case (fn)
         FN_ZERO:                   y = '0;
         FN_ADD, FN_ASUBB, FN_BSUBA: y = sum;
         FN_XOR:                    y = a ^ b;
         FN_OR:                     y = a | b;
         FN_AND:                    y = a & b;
         default:                   y = '1;
      endcase
   end

endmodule

// File: rtl/tds_operand_reg.sv
module tds_operand_reg #(
   parameter int           W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= INIT;
      else if (load) q <= d;
   end

   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

   assert_capture_on_load_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));

endmodule

// File: rtl/tds_ctrl_table.sv
module tds_ctrl_table
   import tds_pkg::*;
#(
   parameter int STATE_W  = 2,
   parameter bit WRITABLE = 1'b1,
   localparam int WORD_W  = STATE_W + FN_W + 2,
   localparam int DEPTH   = 1 << STATE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               we,
   input  logic [STATE_W-1:0] waddr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [STATE_W-1:0] raddr,
   output logic [WORD_W-1:0]  rword
);

   // Default program: add into A, subtract into B, OR into A; others idle to 0
   function automatic logic [WORD_W-1:0] boot_word(input logic [STATE_W-1:0] s);
      case (s)
         STATE_W'(0): return {STATE_W'(1), FN_ADD,   2'b10};
         STATE_W'(1): return {STATE_W'(2), FN_ASUBB, 2'b01};
         STATE_W'(2): return {STATE_W'(0), FN_OR,    2'b10};
         default:     return {STATE_W'(0), FN_ZERO,  2'b00};
      endcase
   endfunction

   generate
      if (WRITABLE) begin : g_ram
         logic [WORD_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= boot_word(STATE_W'(i));
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end

         assign rword = mem[raddr];

         assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
            we |=> mem[$past(waddr)] == $past(wdata));
      end else begin : g_rom
         logic unused_wr;
         assign unused_wr = ^{clk, rst, we, waddr, wdata};
         always_comb rword = boot_word(raddr);
      end
   endgenerate

endmodule

// File: rtl/tds_sequencer.sv
module tds_sequencer
   import tds_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                STATE_W  = 2,
   parameter bit                WRITABLE = 1'b1,
   parameter logic [DATA_W-1:0] A_INIT   = '0,
   parameter logic [DATA_W-1:0] B_INIT   = '0,
   localparam int               WORD_W   = STATE_W + FN_W + 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tbl_we,
   input  logic [STATE_W-1:0] tbl_addr,
   input  logic [WORD_W-1:0]  tbl_wdata,
   output logic [STATE_W-1:0] state,
   output logic [FN_W-1:0]    fn,
   output logic               load_a,
   output logic               load_b,
   output logic [DATA_W-1:0]  a_val,
   output logic [DATA_W-1:0]  b_val
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("tds_sequencer: DATA_W must be at least 1");
   end
   if (STATE_W < 2) begin : g_bad_state_w
      $error("tds_sequencer: STATE_W must be at least 2 for the default program");
   end

   logic [WORD_W-1:0]  word;
   logic [STATE_W-1:0] nxt;
   alu_fn_e            alu_fn;
   logic [DATA_W-1:0]  alu_y;

   tds_ctrl_table #(.STATE_W(STATE_W), .WRITABLE(WRITABLE)) u_table (
      .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr),
      .wdata(tbl_wdata), .raddr(state), .rword(word)
   );

   assign nxt    = word[WORD_W-1 -: STATE_W];
   assign alu_fn = alu_fn_e'(word[2 +: FN_W]);
   assign load_a = word[1];
   assign load_b = word[0];
   assign fn     = word[2 +: FN_W];

   always_ff @(posedge clk) begin
      if (rst) state <= '0;
      else     state <= nxt;
   end

   tds_alu #(.W(DATA_W)) u_alu (.a(a_val), .b(b_val), .fn(alu_fn), .y(alu_y));

   tds_operand_reg #(.W(DATA_W), .INIT(A_INIT)) u_reg_a (
      .clk(clk), .rst(rst), .load(load_a), .d(alu_y), .q(a_val)
   );
   tds_operand_reg #(.W(DATA_W), .INIT(B_INIT)) u_reg_b (
      .clk(clk), .rst(rst), .load(load_b), .d(alu_y), .q(b_val)
   );

   assert_state_follows_word_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> state == $past(word[WORD_W-1 -: STATE_W]));

   assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
      (alu_fn == FN_ADD) |-> alu_y == DATA_W'(a_val + b_val));

   assert_sub_exact_R3: assert property (@(posedge clk) disable iff (rst)
      (alu_fn == FN_ASUBB) |-> alu_y == DATA_W'(a_val - b_val));

   assert_reset_values_R1: assert property (@(posedge clk)
      $past(rst) |-> (state == '0 && a_val == A_INIT && b_val == B_INIT));

endmodule

// File: tb/tds_sequencer_bench.sv
module tds_sequencer_bench;

   localparam int          CLK_PERIOD = 10;
   localparam logic [7:0]  AI = 8'h12;
   localparam logic [7:0]  BI = 8'h07;

   typedef struct {
      string      tag;
      logic [1:0] st;
      logic [2:0] f;
      logic       la, lb;
      logic [7:0] a, b;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tbl_we = 1'b0;
   logic [1:0] tbl_addr = '0;
   logic [6:0] tbl_wdata = '0;
   logic [1:0] state;
   logic [2:0] fn;
   logic       load_a, load_b;
   logic [7:0] a_val, b_val;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   // Bench model state
   logic [6:0] mt [4];
   logic [1:0] ms;
   logic [7:0] ma, mb;

   always #(CLK_PERIOD/2) clk = ~clk;

   tds_sequencer #(.DATA_W(8), .STATE_W(2), .WRITABLE(1'b1), .A_INIT(AI), .B_INIT(BI))
   u_tds_sequencer (
      .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .state(state), .fn(fn), .load_a(load_a), .load_b(load_b), .a_val(a_val), .b_val(b_val)
   );

   function automatic logic [6:0] dflt(int s);
      case (s)
         0: return 7'b01_011_10;
         1: return 7'b10_010_01;
         2: return 7'b00_101_10;
         default: return 7'b00_000_00;
      endcase
   endfunction

   function automatic logic [7:0] ref_alu(logic [2:0] f, logic [7:0] x, logic [7:0] y);
      case (f)
         3'b000: return 8'h00;
         3'b001: return y - x;
         3'b010: return x - y;
         3'b011: return x + y;
         3'b100: return x ^ y;
         3'b101: return x | y;
         3'b110: return x & y;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic string auto_tag(logic [1:0] s);
      case (s)
         2'd0: return "R2 R6";
         2'd1: return "R3 R6";
         2'd2: return "R4 R5 R6";
         default: return "R9";
      endcase
   endfunction

   // Driver: applies one clock of stimulus and queues the expected result
   task automatic step(string tag, logic r, logic we, logic [1:0] ad, logic [6:0] wd);
      logic [6:0] w;
      logic [7:0] y;
      exp_t e;
      @(negedge clk);
      rst = r; tbl_we = we; tbl_addr = ad; tbl_wdata = wd;
      if (tag == "") tag = auto_tag(ms);
      w = mt[ms];
      y = ref_alu(w[4:2], ma, mb);
      if (r) begin
         ms = 2'd0; ma = AI; mb = BI;
         for (int i = 0; i < 4; i++) mt[i] = dflt(i);
      end else begin
         if (w[1]) ma = y;
         if (w[0]) mb = y;
         if (we) mt[ad] = wd;
         ms = w[6:5];
      end
      @(posedge clk);
      #1;
      e.tag = tag; e.st = ms; e.f = mt[ms][4:2]; e.la = mt[ms][1]; e.lb = mt[ms][0];
      e.a = ma; e.b = mb;
      sb.push_back(e);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step("", 1'b0, 1'b0, 2'd0, 7'd0);
   endtask

   task automatic run_to_state(logic [1:0] s);
      for (int i = 0; i < 8 && ms != s; i++) step("", 1'b0, 1'b0, 2'd0, 7'd0);
   endtask

   // Monitor: compares queued expectations against the ports at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (state !== e.st || fn !== e.f || load_a !== e.la || load_b !== e.lb ||
                a_val !== e.a || b_val !== e.b) begin
               failures++;
               $display("FAIL %s: got st=%0d fn=%0d la=%0b lb=%0b A=%02h B=%02h exp st=%0d fn=%0d la=%0b lb=%0b A=%02h B=%02h",
                        e.tag, state, fn, load_a, load_b, a_val, b_val,
                        e.st, e.f, e.la, e.lb, e.a, e.b);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) mt[i] = dflt(i);
      ms = 2'd0; ma = AI; mb = BI;

      // R1: reset values
      step("R1", 1'b1, 1'b0, 2'd0, 7'd0);
      step("R1", 1'b1, 1'b0, 2'd0, 7'd0);

      // R2, R3, R4, R5, R6: default program loops, with wraparound
      run(36);

      // R8: rewrite the word of the current state (S0) to AND into B
      run_to_state(2'd0);
      step("R8 R7", 1'b0, 1'b1, 2'd0, 7'b01_110_01);
      step("R8", 1'b0, 1'b0, 2'd0, 7'd0);
      step("R8", 1'b0, 1'b0, 2'd0, 7'd0);
      step("R8", 1'b0, 1'b0, 2'd0, 7'd0);
      run(3);

      // R11: reset concurrent with a write restores the default table
      step("R11", 1'b1, 1'b1, 2'd1, 7'b11_111_11);
      step("R11", 1'b0, 1'b0, 2'd0, 7'd0);
      run(5);

      // R9: route S2 into the unused state, then back to S0
      run_to_state(2'd1);
      step("R9 R7", 1'b0, 1'b1, 2'd2, 7'b11_101_10);
      step("R9", 1'b0, 1'b0, 2'd0, 7'd0);
      step("R9", 1'b0, 1'b0, 2'd0, 7'd0);
      run(4);

      // R10: program the other function codes
      run_to_state(2'd2);
      step("R10 R7", 1'b0, 1'b1, 2'd0, 7'b01_001_10);
      step("R10 R7", 1'b0, 1'b1, 2'd1, 7'b10_100_01);
      step("R10 R7", 1'b0, 1'b1, 2'd2, 7'b11_111_01);
      step("R10 R7", 1'b0, 1'b1, 2'd3, 7'b00_000_10);
      for (int i = 0; i < 8; i++) step("R10", 1'b0, 1'b0, 2'd0, 7'd0);
      step("R10 R7", 1'b0, 1'b1, 2'd3, 7'b00_110_10);
      for (int i = 0; i < 8; i++) step("R10", 1'b0, 1'b0, 2'd0, 7'd0);

      // R6: a word with no load bits leaves both registers alone
      step("R6 R7", 1'b0, 1'b1, 2'd0, 7'b01_111_00);
      run(6);

      // R11: reset again and confirm the default loop resumes
      step("R11", 1'b1, 1'b0, 2'd0, 7'd0);
      run(6);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule